// File: doc/BRIEF.md
# Duty-Cycled Sensing Power Sequencer

This block runs one measurement cycle of a battery-powered environmental sensing endpoint each time a real-time-clock tick arrives while it is asleep. It powers the sensor rail, asks the bus engine for a sanity check, starts the fast temperature/humidity and pressure measurement and, on selected cycles, powers a separate heater/front-end rail for a VOC warm-up and a VOC sample. When the cycle is over it drops both rails and sleeps again.

The bus transactions, the compensation arithmetic and the heater drive itself sit outside. Each of them appears here as a start strobe going out and a done pulse coming back. Every done pulse is guarded by a programmable cycle limit. The VOC path runs on every Nth accepted tick, or on the cycle after an event request. Every VOC result leaves with a quality tag rather than as a bare value.

Top module: `sense_cycle_seq`

## Requirements
- R1: After reset the block is asleep: `sensor_en`, `heater_en`, `cycle_active` and every strobe are 0, `seg_code` is 0 and `fault_count` is 0.
- R2: An accepted tick starts a cycle whose segments always come in the same order. The codes are sleep=0, wake=1, measure=2, warm-up=3, VOC sample=4 and shutdown=5. `sanity_start` pulses when wake is entered. `meas_start` pulses when the measure segment is entered after a clean or timed-out sanity check.
- R3: With `cfg_voc_div`=N≠0, the VOC path runs on the Nth accepted tick counted from reset and on every Nth tick after that. With N=0 it runs only on request.
- R4: A `voc_event` pulse forces the VOC path on the next cycle and leaves the cadence count unchanged.
- R5: `sensor_en` is high in every active segment. `heater_en` is high only in warm-up and VOC sample, so it never rises in a cycle without VOC.
- R6: The warm-up lasts `cfg_warm_len` cycles. A VOC result gets tag 01 (valid) when `cfg_warm_len` ≥ STAB_CYCLES, and tag 00 (warming) when it is shorter.
- R7: If a done pulse misses its segment's limit (`cfg_wake_len`, `cfg_meas_len`, `cfg_voc_len`), the sequencer moves on. Any VOC result later in that cycle gets tag 10 (suspect), which takes priority over warming.
- R8: A sanity done that arrives with `sanity_fault` set skips every measurement segment and goes through shutdown to sleep. It also adds one to `fault_count`, which saturates at its maximum.
- R9: A shutdown segment with both rails off always comes before sleep. `cycle_active` is high from wake through shutdown.
- R10: A tick that arrives while a cycle is active is ignored: it starts no further cycle and does not advance the cadence count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | Wake request from the real-time clock |
| voc_event | input | 1 | Request for VOC on the next cycle |
| cfg_wake_len | input | LEN_W | Cycle limit for the sanity done pulse |
| cfg_meas_len | input | LEN_W | Cycle limit for the measurement done pulse |
| cfg_warm_len | input | LEN_W | Warm-up length in cycles |
| cfg_voc_len | input | LEN_W | Cycle limit for the VOC done pulse |
| cfg_voc_div | input | DIV_W | VOC cadence N (0 = on request only) |
| sanity_done | input | 1 | Bus sanity check finished |
| sanity_fault | input | 1 | Bus fault reported with sanity_done |
| meas_done | input | 1 | Temperature/humidity and pressure window finished |
| voc_done | input | 1 | VOC sample finished |
| sensor_en | output | 1 | Sensor power rail enable |
| heater_en | output | 1 | Heater/front-end rail enable |
| sanity_start | output | 1 | Start strobe for the bus sanity check |
| meas_start | output | 1 | Start strobe for the fast measurements |
| voc_start | output | 1 | Start strobe for the VOC sample |
| voc_result_valid | output | 1 | One-cycle pulse: VOC tag is new |
| voc_tag | output | 2 | 00 warming, 01 valid, 10 suspect |
| fault_count | output | FAULT_W | Saturating count of bus-fault cycles |
| cycle_active | output | 1 | High while a cycle is in progress |
| seg_code | output | 3 | Current segment code |

## Verification
`sanity_start` and `sensor_en` are both registered, so they appear one clock after the edge that samples the tick. Each later strobe appears one clock after the edge that sees the previous done pulse or the expiry of its limit. `voc_result_valid`, its tag and the drop of `heater_en` all fall on the cycle after the edge that ends the VOC sample. The bench drives every input at the falling edge and samples at the falling edge, so each registered result is read half a clock after the edge that produced it. Its responders return done pulses two falling edges after they see a strobe, well inside the programmed limits; a hung responder forces the limit instead. The bench checks rail activity, fault counts and strobe history only after `cycle_active` has fallen and one more falling edge has passed. The monitor matches each tag pulse against the queue entry that the driver task pushed when it started the cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        SEG_SLEEP = 3'd0,
        SEG_WAKE  = 3'd1,
        SEG_MEAS  = 3'd2,
        SEG_WARM  = 3'd3,
        SEG_VOCS  = 3'd4,
        SEG_SHUT  = 3'd5
    } seg_e;

    localparam logic [1:0] TAG_WARMING = 2'b00;
    localparam logic [1:0] TAG_VALID   = 2'b01;
    localparam logic [1:0] TAG_SUSPECT = 2'b10;

    typedef struct packed {
        seg_e       seg;
        logic       run_voc;
        logic       suspect;
        logic       san_start;
        logic       meas_start;
        logic       voc_start;
        logic       res_valid;
        logic [1:0] tag;
    } seq_state_t;

endpackage

// File: rtl/seg_timer.sv
module seg_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LEN_W-1:0] limit,
    output logic             expired
);
    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [CW-1:0]    cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + CW'(1);
        expired  = (cnt_next >= {1'b0, limit});
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_next[LEN_W]) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_next[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/voc_cadence.sv
module voc_cadence #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_take,
    input  logic             evt_in,
    input  logic             consume,
    input  logic [DIV_W-1:0] div,
    output logic             run
);
    logic [DIV_W-1:0] cad_d, cad_q;
    logic             pend_d, pend_q;
    logic             due;

    always_comb begin
        due    = (div != '0) && (cad_q == div - DIV_W'(1));
        run    = due || pend_q || evt_in;
        cad_d  = cad_q;
        if (tick_take && (div != '0)) begin
            cad_d = due ? '0 : cad_q + DIV_W'(1);
        end
        pend_d = evt_in || (pend_q && !consume);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cad_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cad_q  <= cad_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/sense_cycle_seq.sv
module sense_cycle_seq
    import seq_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int DIV_W       = 4,
    parameter int FAULT_W     = 4,
    parameter int STAB_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rtc_tick,
    input  logic               voc_event,
    input  logic [LEN_W-1:0]   cfg_wake_len,
    input  logic [LEN_W-1:0]   cfg_meas_len,
    input  logic [LEN_W-1:0]   cfg_warm_len,
    input  logic [LEN_W-1:0]   cfg_voc_len,
    input  logic [DIV_W-1:0]   cfg_voc_div,
    input  logic               sanity_done,
    input  logic               sanity_fault,
    input  logic               meas_done,
    input  logic               voc_done,
    output logic               sensor_en,
    output logic               heater_en,
    output logic               sanity_start,
    output logic               meas_start,
    output logic               voc_start,
    output logic               voc_result_valid,
    output logic [1:0]         voc_tag,
    output logic [FAULT_W-1:0] fault_count,
    output logic               cycle_active,
    output logic [2:0]         seg_code
);
    localparam logic [LEN_W-1:0] STAB_LEN = LEN_W'(STAB_CYCLES);

    seq_state_t st_d, st_q;
    logic [LEN_W-1:0] limit;
    logic             tmo, clr_tmr, tick_take, consume, run_now, fault_inc;
    logic             short_warm;

    seg_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(clr_tmr), .limit(limit), .expired(tmo)
    );

    voc_cadence #(.DIV_W(DIV_W)) u_cadence (
        .clk(clk), .rst_n(rst_n), .tick_take(tick_take), .evt_in(voc_event),
        .consume(consume), .div(cfg_voc_div), .run(run_now)
    );

    sat_counter #(.W(FAULT_W)) u_faults (
        .clk(clk), .rst_n(rst_n), .inc(fault_inc), .count(fault_count)
    );

    always_comb begin
        unique case (st_q.seg)
            SEG_WAKE: limit = cfg_wake_len;
            SEG_MEAS: limit = cfg_meas_len;
            SEG_WARM: limit = cfg_warm_len;
            SEG_VOCS: limit = cfg_voc_len;
            default:  limit = '0;
        endcase
    end

    assign short_warm = (cfg_warm_len < STAB_LEN);

    always_comb begin
        st_d            = st_q;
        st_d.san_start  = 1'b0;
        st_d.meas_start = 1'b0;
        st_d.voc_start  = 1'b0;
        st_d.res_valid  = 1'b0;
        tick_take       = 1'b0;
        consume         = 1'b0;
        fault_inc       = 1'b0;

        unique case (st_q.seg)
            SEG_SLEEP: begin
                if (rtc_tick) begin
                    tick_take      = 1'b1;
                    st_d.seg       = SEG_WAKE;
                    st_d.san_start = 1'b1;
                    st_d.run_voc   = run_now;
                    st_d.suspect   = 1'b0;
                end
            end
            SEG_WAKE: begin
                if (sanity_done && sanity_fault) begin
                    fault_inc = 1'b1;
                    st_d.seg  = SEG_SHUT;
                end else if (sanity_done || tmo) begin
                    st_d.suspect    = st_q.suspect || !sanity_done;
                    st_d.seg        = SEG_MEAS;
                    st_d.meas_start = 1'b1;
                end
            end
            SEG_MEAS: begin
                if (meas_done || tmo) begin
                    st_d.suspect = st_q.suspect || !meas_done;
                    if (st_q.run_voc) begin
                        consume  = 1'b1;
                        st_d.seg = SEG_WARM;
                    end else begin
                        st_d.seg = SEG_SHUT;
                    end
                end
            end
            SEG_WARM: begin
                if (tmo) begin
                    st_d.seg       = SEG_VOCS;
                    st_d.voc_start = 1'b1;
                end
            end
            SEG_VOCS: begin
                if (voc_done || tmo) begin
                    st_d.res_valid = 1'b1;
                    st_d.seg       = SEG_SHUT;
                    if (st_q.suspect || !voc_done) st_d.tag = TAG_SUSPECT;
                    else if (short_warm)           st_d.tag = TAG_WARMING;
                    else                           st_d.tag = TAG_VALID;
                end
            end
            default: begin
                st_d.seg = SEG_SLEEP;
            end
        endcase
        clr_tmr = (st_d.seg != st_q.seg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.seg <= SEG_SLEEP;
        end else begin
            st_q <= st_d;
        end
    end

    assign sensor_en        = (st_q.seg == SEG_WAKE) || (st_q.seg == SEG_MEAS) ||
                              (st_q.seg == SEG_WARM) || (st_q.seg == SEG_VOCS);
    assign heater_en        = (st_q.seg == SEG_WARM) || (st_q.seg == SEG_VOCS);
    assign sanity_start     = st_q.san_start;
    assign meas_start       = st_q.meas_start;
    assign voc_start        = st_q.voc_start;
    assign voc_result_valid = st_q.res_valid;
    assign voc_tag          = st_q.tag;
    assign cycle_active     = (st_q.seg != SEG_SLEEP);
    assign seg_code         = st_q.seg;
endmodule

// File: rtl/sense_cycle_seq_chk.sv
module sense_cycle_seq_chk #(
    parameter int FAULT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sensor_en,
    input logic               heater_en,
    input logic               sanity_start,
    input logic               meas_start,
    input logic               voc_start,
    input logic               voc_result_valid,
    input logic [1:0]         voc_tag,
    input logic [FAULT_W-1:0] fault_count,
    input logic               cycle_active,
    input logic [2:0]         seg_code
);
    assert_heater_needs_sensor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        heater_en |-> sensor_en);

    assert_heater_after_meas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(heater_en) |-> $past(seg_code) == 3'd2);

    assert_meas_after_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> $past(seg_code) == 3'd1);

    assert_sanity_on_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sanity_start |-> $past(!cycle_active));

    assert_voc_start_after_warm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        voc_start |-> $past(seg_code) == 3'd3);

    assert_tag_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        voc_result_valid |-> (voc_tag != 2'b11) && !heater_en);

    assert_rails_off_at_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cycle_active) |-> !sensor_en && !heater_en && $past(seg_code) == 3'd5);

    assert_fault_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_count != $past(fault_count)) |-> (fault_count == $past(fault_count) + 1'b1));
endmodule

bind sense_cycle_seq sense_cycle_seq_chk #(.FAULT_W(FAULT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sensor_en(sensor_en), .heater_en(heater_en),
    .sanity_start(sanity_start), .meas_start(meas_start), .voc_start(voc_start),
    .voc_result_valid(voc_result_valid), .voc_tag(voc_tag),
    .fault_count(fault_count), .cycle_active(cycle_active), .seg_code(seg_code)
);

// File: tb/sense_cycle_seq_test.sv
module sense_cycle_seq_test;
    localparam int LEN_W = 8, DIV_W = 4, FAULT_W = 4, STAB = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rtc_tick = 0, voc_event = 0;
    logic [LEN_W-1:0] cfg_wake_len = 8, cfg_meas_len = 8, cfg_warm_len = 20, cfg_voc_len = 8;
    logic [DIV_W-1:0] cfg_voc_div = 3;
    logic sanity_done = 0, sanity_fault = 0, meas_done = 0, voc_done = 0;
    logic sensor_en, heater_en, sanity_start, meas_start, voc_start, voc_result_valid;
    logic [1:0] voc_tag;
    logic [FAULT_W-1:0] fault_count;
    logic cycle_active;
    logic [2:0] seg_code;

    always #10 clk = ~clk;

    sense_cycle_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W), .FAULT_W(FAULT_W), .STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .voc_event(voc_event),
        .cfg_wake_len(cfg_wake_len), .cfg_meas_len(cfg_meas_len), .cfg_warm_len(cfg_warm_len),
        .cfg_voc_len(cfg_voc_len), .cfg_voc_div(cfg_voc_div), .sanity_done(sanity_done),
        .sanity_fault(sanity_fault), .meas_done(meas_done), .voc_done(voc_done),
        .sensor_en(sensor_en), .heater_en(heater_en), .sanity_start(sanity_start),
        .meas_start(meas_start), .voc_start(voc_start), .voc_result_valid(voc_result_valid),
        .voc_tag(voc_tag), .fault_count(fault_count), .cycle_active(cycle_active),
        .seg_code(seg_code)
    );

    int checks = 0, failures = 0;
    bit fault_mode = 0, hang_san = 0, hang_meas = 0, hang_voc = 0;
    bit saw_heat, saw_meas, saw_san;
    int model_cad = 0, model_fault = 0;
    bit model_pend = 0;
    logic [1:0] exp_tags[$];
    string      exp_reqs[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // responders
    initial forever begin
        @(negedge clk);
        if (sanity_start && !hang_san) begin
            repeat (2) @(negedge clk);
            sanity_done = 1; sanity_fault = fault_mode;
            @(negedge clk);
            sanity_done = 0; sanity_fault = 0;
        end
    end
    initial forever begin
        @(negedge clk);
        if (meas_start && !hang_meas) begin
            repeat (2) @(negedge clk);
            meas_done = 1;
            @(negedge clk);
            meas_done = 0;
        end
    end
    initial forever begin
        @(negedge clk);
        if (voc_start && !hang_voc) begin
            repeat (2) @(negedge clk);
            voc_done = 1;
            @(negedge clk);
            voc_done = 0;
        end
    end

    // monitor
    initial forever begin
        @(negedge clk);
        if (heater_en) saw_heat = 1;
        if (meas_start) saw_meas = 1;
        if (sanity_start) saw_san = 1;
        if (voc_result_valid) begin
            if (exp_tags.size() == 0) begin
                check(0, "R3 unexpected VOC result", 1, 0);
            end else begin
                logic [1:0] t;
                string r;
                t = exp_tags.pop_front();
                r = exp_reqs.pop_front();
                check(voc_tag == t, r, voc_tag, t);
            end
        end
    end

    task automatic pulse_event();
        @(negedge clk); voc_event = 1;
        @(negedge clk); voc_event = 0;
        model_pend = 1;
    endtask

    task automatic run_cycle(input bit f, input bit hm, input bit hv, input bit dbl, input string req);
        bit due, run, exp_voc;
        int wd;
        due = (cfg_voc_div != 0) && (model_cad == cfg_voc_div - 1);
        if (cfg_voc_div != 0) model_cad = due ? 0 : model_cad + 1;
        run = due || model_pend;
        exp_voc = run && !f;
        if (exp_voc) begin
            model_pend = 0;
            exp_tags.push_back((hm || hv) ? 2'b10 : ((cfg_warm_len < STAB) ? 2'b00 : 2'b01));
            exp_reqs.push_back((hm || hv) ? "R7 tag" : ((cfg_warm_len < STAB) ? "R6 warming tag" : "R6 valid tag"));
        end
        if (f && model_fault < 15) model_fault++;
        fault_mode = f; hang_meas = hm; hang_voc = hv;
        saw_heat = 0; saw_meas = 0; saw_san = 0;
        @(negedge clk); rtc_tick = 1;
        @(negedge clk); rtc_tick = 0;
        check(sensor_en && cycle_active, "R2 rails up after tick", sensor_en, 1);
        if (dbl) begin
            repeat (2) @(negedge clk);
            rtc_tick = 1;
            @(negedge clk); rtc_tick = 0;
        end
        wd = 0;
        while (cycle_active && wd < 2000) begin
            @(negedge clk); wd++;
        end
        check(wd < 2000, "R2 cycle completes", wd, 0);
        @(negedge clk);
        check(saw_san, "R2 sanity strobe", saw_san, 1);
        check(saw_heat == exp_voc, {req, " heater activity"}, saw_heat, exp_voc);
        check(saw_meas == !f, "R8 measurement skip", saw_meas, !f);
        check(fault_count == model_fault, "R8 fault count", fault_count, model_fault);
        check(!sensor_en && !heater_en, "R9 rails off in sleep", sensor_en, 0);
        if (dbl) begin
            repeat (5) @(negedge clk);
            check(!cycle_active, "R10 tick ignored while active", cycle_active, 0);
        end
        hang_meas = 0; hang_voc = 0; fault_mode = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!sensor_en && !heater_en, "R1 rails off in reset", sensor_en, 0);
        check(!cycle_active && seg_code == 0, "R1 asleep", seg_code, 0);
        rst_n = 1;
        @(negedge clk);
        check(fault_count == 0, "R1 fault count", fault_count, 0);
        check(!sanity_start && !meas_start && !voc_start && !voc_result_valid, "R1 strobes", 1, 0);

        // cadence N=3
        run_cycle(0, 0, 0, 0, "R3");
        run_cycle(0, 0, 0, 0, "R3");
        run_cycle(0, 0, 0, 0, "R3");
        // event forces VOC on next cycle
        pulse_event();
        run_cycle(0, 0, 0, 0, "R4");
        run_cycle(0, 0, 0, 0, "R4");
        run_cycle(0, 0, 0, 0, "R3");
        // short warm-up gives warming tag
        cfg_warm_len = 5;
        pulse_event();
        run_cycle(0, 0, 0, 0, "R6");
        cfg_warm_len = 20;
        // timeouts give suspect
        pulse_event();
        run_cycle(0, 1, 0, 0, "R7");
        pulse_event();
        run_cycle(0, 0, 1, 0, "R7");
        // bus fault
        run_cycle(1, 0, 0, 0, "R8");
        // tick during active cycle
        run_cycle(0, 0, 0, 1, "R10");
        // N=0: only on request
        cfg_voc_div = 0;
        run_cycle(0, 0, 0, 0, "R3");
        run_cycle(0, 0, 0, 0, "R3");
        run_cycle(0, 0, 0, 0, "R3");
        pulse_event();
        run_cycle(0, 0, 0, 0, "R4");
        // saturation
        for (int i = 0; i < 16; i++) run_cycle(1, 0, 0, 0, "R8");
        check(fault_count == 15, "R8 saturation", fault_count, 15);
        check(exp_tags.size() == 0, "R5 all VOC results seen", exp_tags.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end
endmodule